// File: doc/BRIEF.md
# Jump Evaluation and Next-Index Unit

This unit takes one decoded instruction at a time and decides where execution goes next. For the two jump classes it evaluates the branch condition and produces the next instruction index. The first operand is the destination register value. The second operand is either the source register value or the sign-extended immediate. A taken jump lands at one target. Otherwise execution falls through to the following instruction. A function call is reported as a one-cycle request that carries the immediate as the function identifier. A program exit is reported as a flag.

Class 5 compares full 64-bit values. Class 6 applies the same conditions to the low 32 bits only. Instructions of any other class simply advance by one. A target outside the program space is a fault. An operation that is not legal in its class is flagged as illegal. An exit, a fault or an illegal operation stops the unit, and it then ignores all input until reset. Results are registered and appear one clock after the instruction is presented.

Top module: `jump_ctl`

## Requirements
- R1: After reset all outputs are 0. An instruction presented with `in_valid` high while the unit is not halted produces `out_valid` high on the next clock, together with its results. `out_valid` is never high without an accepted instruction one cycle earlier.
- R2: Opcode bit 3 selects the second comparison operand. 0 selects the 32-bit immediate, sign-extended to 64 bits. 1 selects `in_src`.
- R3: Opcode bits 7:4 select the condition. 0x1 is taken on equality, 0x5 on inequality, and 0x4 when the bitwise AND of the operands is nonzero.
- R4: Unsigned conditions: 0x2 is greater, 0x3 is greater-or-equal, 0xa is less, and 0xb is less-or-equal.
- R5: Signed (two's complement) conditions: 0x6 is greater, 0x7 is greater-or-equal, 0xc is less, and 0xd is less-or-equal.
- R6: Opcode bits 2:0 give the class. Class 5 compares 64-bit operands. Class 6 compares only bits 31:0 of both operands, and takes bit 31 as the sign for the signed conditions.
- R7: A taken jump sets `out_taken` and gives next index = index + 1 + the sign-extended 16-bit offset. A jump that is not taken gives index + 1 with `out_taken` low.
- R8: Operation 0x0 in class 5 is always taken.
- R9: Operation 0x8 in class 5 raises `out_call` for exactly one cycle with `out_fn_id` equal to the immediate, gives next index = index + 1, and leaves `out_taken` low.
- R10: Operation 0x9 in class 5 raises `out_exit`, returns the current index as the next index, and halts the unit.
- R11: A next index outside 0 to DEPTH-1 (4096 by default) raises `out_fault` instead of `out_taken`, returns the current index, and halts the unit.
- R12: Operations 0x0, 0x8 and 0x9 in class 6, and operations 0xe and 0xf in either jump class, raise `out_illegal`, return the current index, and halt the unit.
- R13: While `out_halted` is high, instructions are ignored (`out_valid` stays 0) until reset.
- R14: An instruction of any class other than 5 or 6 gives index + 1 with every flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 8 | Opcode byte |
| in_dst | input | 64 | Destination register value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate field |
| in_off | input | 16 | Signed jump offset |
| in_idx | input | 12 | Index of the current instruction |
| out_valid | output | 1 | Result present |
| out_idx | output | 12 | Next instruction index |
| out_taken | output | 1 | Jump taken |
| out_call | output | 1 | Function call request (one cycle) |
| out_fn_id | output | 32 | Function identifier of the call |
| out_exit | output | 1 | Program exit |
| out_fault | output | 1 | Next index out of range |
| out_illegal | output | 1 | Operation illegal in its class |
| out_halted | output | 1 | Unit stopped until reset |

## Verification
Every result, including the halted flag, is due exactly one clock after the instruction is presented. The bench drives each instruction on a falling edge and samples all outputs on the next falling edge, which falls between the capturing rising edge and the following one. The call pulse gets one more sample a cycle later, where it must be low. After a halting event, a further instruction is presented and `out_valid` is checked one cycle later to confirm it was ignored.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam logic [2:0] CLS_J64 = 3'd5;
  localparam logic [2:0] CLS_J32 = 3'd6;

  localparam logic [3:0] OP_ALWAYS = 4'h0;
  localparam logic [3:0] OP_EQ     = 4'h1;
  localparam logic [3:0] OP_UGT    = 4'h2;
  localparam logic [3:0] OP_UGE    = 4'h3;
  localparam logic [3:0] OP_BITS   = 4'h4;
  localparam logic [3:0] OP_NE     = 4'h5;
  localparam logic [3:0] OP_SGT    = 4'h6;
  localparam logic [3:0] OP_SGE    = 4'h7;
  localparam logic [3:0] OP_CALL   = 4'h8;
  localparam logic [3:0] OP_EXIT   = 4'h9;
  localparam logic [3:0] OP_ULT    = 4'ha;
  localparam logic [3:0] OP_ULE    = 4'hb;
  localparam logic [3:0] OP_SLT    = 4'hc;
  localparam logic [3:0] OP_SLE    = 4'hd;

  typedef enum logic [2:0] {
    K_NONE, K_COND, K_ALWAYS, K_CALL, K_EXIT, K_BAD
  } jkind_e;
endpackage

// File: rtl/jc_decode.sv
module jc_decode
  import jc_pkg::*;
(
  input  logic [7:0] op,
  output logic       is_jump,
  output logic       is_narrow,
  output logic       use_reg,
  output logic [3:0] code,
  output jkind_e     kind
);
  logic [2:0] cls;
  assign cls       = op[2:0];
  assign code      = op[7:4];
  assign use_reg   = op[3];
  assign is_jump   = (cls == CLS_J64) || (cls == CLS_J32);
  assign is_narrow = (cls == CLS_J32);

  always_comb begin
    kind = K_NONE;
    if (is_jump) begin
      unique case (code)
        OP_ALWAYS: kind = is_narrow ? K_BAD : K_ALWAYS;
        OP_CALL:   kind = is_narrow ? K_BAD : K_CALL;
        OP_EXIT:   kind = is_narrow ? K_BAD : K_EXIT;
        4'he, 4'hf: kind = K_BAD;
        default:   kind = K_COND;
      endcase
    end
  end
endmodule

// File: rtl/jc_cond.sv
module jc_cond
  import jc_pkg::*;
#(
  parameter int DW = 64,
  parameter int IMW = 32
) (
  input  logic [DW-1:0]  a_dst,
  input  logic [DW-1:0]  a_src,
  input  logic [IMW-1:0] imm,
  input  logic           use_reg,
  input  logic           narrow,
  input  logic [3:0]     code,
  output logic           hit
);
  localparam int NW = 32;

  function automatic logic [DW-1:0] widen_imm(input logic [IMW-1:0] v);
    return {{(DW-IMW){v[IMW-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] as_unsigned(input logic [DW-1:0] v, input logic n);
    return n ? {{(DW-NW){1'b0}}, v[NW-1:0]} : v;
  endfunction

  function automatic logic [DW-1:0] as_signed(input logic [DW-1:0] v, input logic n);
    return n ? {{(DW-NW){v[NW-1]}}, v[NW-1:0]} : v;
  endfunction

  logic [DW-1:0] rhs, lu, ru, ls, rs;
  logic eq_w, ult_w, slt_w, bits_w;

  assign rhs    = use_reg ? a_src : widen_imm(imm);
  assign lu     = as_unsigned(a_dst, narrow);
  assign ru     = as_unsigned(rhs, narrow);
  assign ls     = as_signed(a_dst, narrow);
  assign rs     = as_signed(rhs, narrow);
  assign eq_w   = (lu == ru);
  assign ult_w  = (lu < ru);
  assign slt_w  = ($signed(ls) < $signed(rs));
  assign bits_w = |(lu & ru);

  always_comb begin
    unique case (code)
      OP_ALWAYS: hit = 1'b1;
      OP_EQ:     hit = eq_w;
      OP_NE:     hit = !eq_w;
      OP_BITS:   hit = bits_w;
      OP_UGT:    hit = !ult_w && !eq_w;
      OP_UGE:    hit = !ult_w;
      OP_ULT:    hit = ult_w;
      OP_ULE:    hit = ult_w || eq_w;
      OP_SGT:    hit = !slt_w && !eq_w;
      OP_SGE:    hit = !slt_w;
      OP_SLT:    hit = slt_w;
      OP_SLE:    hit = slt_w || eq_w;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/jc_target.sv
module jc_target #(
  parameter int IW = 12,
  parameter int DEPTH = 4096,
  parameter int OFW = 16
) (
  input  logic [IW-1:0]  idx,
  input  logic [OFW-1:0] off,
  input  logic           take,
  output logic [IW-1:0]  nxt,
  output logic           oob
);
  localparam int TW = ((IW > OFW) ? IW : OFW) + 2;

  function automatic logic signed [TW-1:0] add_disp(
    input logic [IW-1:0] base, input logic [OFW-1:0] d, input logic use_d);
    logic signed [TW-1:0] b, e;
    b = $signed({{(TW-IW){1'b0}}, base});
    e = use_d ? $signed({{(TW-OFW){d[OFW-1]}}, d}) : '0;
    return b + e + TW'(1);
  endfunction

  logic signed [TW-1:0] tgt;
  logic signed [TW-1:0] limit;

  assign limit = TW'(DEPTH);
  assign tgt   = add_disp(idx, off, take);
  assign oob   = (tgt < 0) || (tgt >= limit);
  assign nxt   = tgt[IW-1:0];
endmodule

// File: rtl/jump_ctl.sv
module jump_ctl
  import jc_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 12,
  parameter int DEPTH = 4096,
  parameter int IMW = 32,
  parameter int OFW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_op,
  input  logic [DW-1:0]  in_dst,
  input  logic [DW-1:0]  in_src,
  input  logic [IMW-1:0] in_imm,
  input  logic [OFW-1:0] in_off,
  input  logic [IW-1:0]  in_idx,
  output logic           out_valid,
  output logic [IW-1:0]  out_idx,
  output logic           out_taken,
  output logic           out_call,
  output logic [IMW-1:0] out_fn_id,
  output logic           out_exit,
  output logic           out_fault,
  output logic           out_illegal,
  output logic           out_halted
);
  logic       is_jump, is_narrow, use_reg, hit, oob;
  logic [3:0] code;
  jkind_e     kind;
  logic [IW-1:0] nxt;

  jc_decode u_dec (
    .op(in_op), .is_jump(is_jump), .is_narrow(is_narrow),
    .use_reg(use_reg), .code(code), .kind(kind)
  );

  jc_cond #(.DW(DW), .IMW(IMW)) u_cond (
    .a_dst(in_dst), .a_src(in_src), .imm(in_imm), .use_reg(use_reg),
    .narrow(is_narrow), .code(code), .hit(hit)
  );

  logic take_w;
  assign take_w = (kind == K_COND || kind == K_ALWAYS) && hit;

  jc_target #(.IW(IW), .DEPTH(DEPTH), .OFW(OFW)) u_tgt (
    .idx(in_idx), .off(in_off), .take(take_w), .nxt(nxt), .oob(oob)
  );

  // named internal events
  logic accept_w, exit_w, bad_w, fault_w, call_w, stop_w;
  assign accept_w = in_valid && !out_halted;
  assign exit_w   = (kind == K_EXIT);
  assign bad_w    = (kind == K_BAD);
  assign fault_w  = oob && !exit_w && !bad_w;
  assign call_w   = (kind == K_CALL) && !fault_w;
  assign stop_w   = exit_w || bad_w || fault_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_idx     <= '0;
      out_taken   <= 1'b0;
      out_call    <= 1'b0;
      out_fn_id   <= '0;
      out_exit    <= 1'b0;
      out_fault   <= 1'b0;
      out_illegal <= 1'b0;
      out_halted  <= 1'b0;
    end else begin
      out_valid   <= accept_w;
      out_taken   <= accept_w && take_w && !fault_w;
      out_call    <= accept_w && call_w;
      out_exit    <= accept_w && exit_w;
      out_fault   <= accept_w && fault_w;
      out_illegal <= accept_w && bad_w;
      if (accept_w) begin
        out_idx <= stop_w ? in_idx : nxt;
        if (call_w) out_fn_id <= in_imm;
        if (stop_w) out_halted <= 1'b1;
      end
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_taken, out_call, out_exit, out_fault, out_illegal}));
  assert_call_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_call |-> ({1'b0, out_idx} == {1'b0, $past(in_idx)} + (IW+1)'(1)) && !out_taken);
  assert_call_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_call |-> out_fn_id == $past(in_imm));
  assert_exit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_exit |-> out_idx == $past(in_idx) && out_halted);
  assert_fault_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_halted && out_idx == $past(in_idx));
  assert_illegal_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_halted);
  assert_halt_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_halted |=> !out_valid && out_halted);
endmodule

// File: tb/sim_jump_ctl.sv
module sim_jump_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_op = '0;
  logic [63:0] in_dst = '0, in_src = '0;
  logic [31:0] in_imm = '0;
  logic [15:0] in_off = '0;
  logic [11:0] in_idx = '0;
  logic out_valid, out_taken, out_call, out_exit, out_fault, out_illegal, out_halted;
  logic [11:0] out_idx;
  logic [31:0] out_fn_id;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  jump_ctl u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm), .in_off(in_off),
    .in_idx(in_idx), .out_valid(out_valid), .out_idx(out_idx),
    .out_taken(out_taken), .out_call(out_call), .out_fn_id(out_fn_id),
    .out_exit(out_exit), .out_fault(out_fault), .out_illegal(out_illegal),
    .out_halted(out_halted)
  );

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present one instruction, sample one cycle later
  task automatic issue(logic [7:0] op, logic [63:0] d, logic [63:0] s,
                       logic [31:0] im, logic [15:0] of, logic [11:0] ix);
    @(negedge clk);
    in_op = op; in_dst = d; in_src = s; in_imm = im; in_off = of; in_idx = ix;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(string req, logic [11:0] ix, logic tk, logic cl,
                            logic ex, logic fl, logic il);
    cmp(req, "valid", 64'(out_valid), 64'(1));
    cmp(req, "idx", 64'(out_idx), 64'(ix));
    cmp(req, "taken", 64'(out_taken), 64'(tk));
    cmp(req, "call", 64'(out_call), 64'(cl));
    cmp(req, "exit", 64'(out_exit), 64'(ex));
    cmp(req, "fault", 64'(out_fault), 64'(fl));
    cmp(req, "illegal", 64'(out_illegal), 64'(il));
  endtask

  task automatic t_reset_state();
    cmp("R1", "valid after reset", 64'(out_valid), 0);
    cmp("R1", "halted after reset", 64'(out_halted), 0);
    cmp("R1", "idx after reset", 64'(out_idx), 0);
    @(negedge clk);
    cmp("R1", "no valid without input", 64'(out_valid), 0);
  endtask

  task automatic t_equality();
    issue(8'h15, 64'd5, 64'd0, 32'd5, 16'd3, 12'd10);
    expect_out("R3 R2 R7 eq imm taken", 12'd14, 1, 0, 0, 0, 0);
    issue(8'h1d, 64'd5, 64'd6, 32'd5, 16'd3, 12'd10);
    expect_out("R2 R3 eq reg not taken", 12'd11, 0, 0, 0, 0, 0);
    issue(8'h5d, 64'd5, 64'd6, 32'd0, 16'd2, 12'd10);
    expect_out("R3 ne taken", 12'd13, 1, 0, 0, 0, 0);
    issue(8'h45, 64'h10, 64'd0, 32'h30, 16'd1, 12'd0);
    expect_out("R3 bit test taken", 12'd2, 1, 0, 0, 0, 0);
    issue(8'h45, 64'h10, 64'd0, 32'h0f, 16'd1, 12'd0);
    expect_out("R3 bit test not taken", 12'd1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_unsigned_signed();
    issue(8'h2d, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 16'd4, 12'd100);
    expect_out("R4 unsigned gt", 12'd105, 1, 0, 0, 0, 0);
    issue(8'h6d, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 16'd4, 12'd100);
    expect_out("R5 signed gt", 12'd101, 0, 0, 0, 0, 0);
    issue(8'ha5, 64'd5, 64'd0, 32'hFFFF_FFFF, 16'd4, 12'd100);
    expect_out("R4 R2 unsigned lt sext imm", 12'd105, 1, 0, 0, 0, 0);
    issue(8'hc5, 64'd5, 64'd0, 32'hFFFF_FFFF, 16'd4, 12'd100);
    expect_out("R5 signed lt", 12'd101, 0, 0, 0, 0, 0);
    issue(8'hdd, 64'd7, 64'd7, 32'd0, 16'd1, 12'd0);
    expect_out("R5 signed le equal", 12'd2, 1, 0, 0, 0, 0);
    issue(8'h3d, 64'd6, 64'd7, 32'd0, 16'd1, 12'd0);
    expect_out("R4 unsigned ge", 12'd1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_narrow();
    issue(8'h16, 64'hABCD_0000_0000_0007, 64'd0, 32'd7, 16'd8, 12'd50);
    expect_out("R6 32-bit eq", 12'd59, 1, 0, 0, 0, 0);
    issue(8'h15, 64'hABCD_0000_0000_0007, 64'd0, 32'd7, 16'd8, 12'd50);
    expect_out("R6 64-bit eq", 12'd51, 0, 0, 0, 0, 0);
    issue(8'h66, 64'h0000_0000_8000_0000, 64'd0, 32'd1, 16'd8, 12'd50);
    expect_out("R6 32-bit signed gt", 12'd51, 0, 0, 0, 0, 0);
    issue(8'h65, 64'h0000_0000_8000_0000, 64'd0, 32'd1, 16'd8, 12'd50);
    expect_out("R6 64-bit signed gt", 12'd59, 1, 0, 0, 0, 0);
  endtask

  task automatic t_always_and_other();
    issue(8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFB, 12'd10);
    expect_out("R8 R7 always negative off", 12'd6, 1, 0, 0, 0, 0);
    issue(8'h07, 64'd1, 64'd2, 32'd3, 16'd9, 12'd30);
    expect_out("R14 other class", 12'd31, 0, 0, 0, 0, 0);
  endtask

  task automatic t_call();
    issue(8'h85, 64'd0, 64'd0, 32'h0000_1234, 16'd7, 12'd20);
    expect_out("R9 call", 12'd21, 0, 1, 0, 0, 0);
    cmp("R9", "fn id", 64'(out_fn_id), 64'h1234);
    @(negedge clk);
    cmp("R9", "call one cycle", 64'(out_call), 0);
  endtask

  task automatic t_exit();
    issue(8'h95, 64'd0, 64'd0, 32'd0, 16'd3, 12'd40);
    expect_out("R10 exit", 12'd40, 0, 0, 1, 0, 0);
    cmp("R10", "halted", 64'(out_halted), 1);
    issue(8'h05, 64'd0, 64'd0, 32'd0, 16'd1, 12'd41);
    cmp("R13", "ignored while halted", 64'(out_valid), 0);
    cmp("R13", "idx unchanged while halted", 64'(out_idx), 64'd40);
    do_reset();
  endtask

  task automatic t_fault();
    issue(8'h05, 64'd0, 64'd0, 32'd0, 16'd10, 12'd4090);
    expect_out("R11 target high", 12'd4090, 0, 0, 0, 1, 0);
    cmp("R11", "halted", 64'(out_halted), 1);
    do_reset();
    issue(8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFB, 12'd2);
    expect_out("R11 target negative", 12'd2, 0, 0, 0, 1, 0);
    do_reset();
    issue(8'h15, 64'd1, 64'd0, 32'd2, 16'd0, 12'd4095);
    expect_out("R11 fall through at end", 12'd4095, 0, 0, 0, 1, 0);
    do_reset();
    issue(8'h05, 64'd0, 64'd0, 32'd0, 16'd0, 12'd4094);
    expect_out("R11 last index ok", 12'd4095, 1, 0, 0, 0, 0);
  endtask

  task automatic t_illegal();
    issue(8'h06, 64'd0, 64'd0, 32'd0, 16'd1, 12'd5);
    expect_out("R12 always in 32 class", 12'd5, 0, 0, 0, 0, 1);
    cmp("R12", "halted", 64'(out_halted), 1);
    do_reset();
    issue(8'h86, 64'd0, 64'd0, 32'd9, 16'd1, 12'd5);
    expect_out("R12 call in 32 class", 12'd5, 0, 0, 0, 0, 1);
    do_reset();
    issue(8'he5, 64'd0, 64'd0, 32'd0, 16'd1, 12'd5);
    expect_out("R12 unknown op", 12'd5, 0, 0, 0, 0, 1);
    issue(8'h07, 64'd0, 64'd0, 32'd0, 16'd0, 12'd6);
    cmp("R13", "ignored after illegal", 64'(out_valid), 0);
    do_reset();
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_equality();
    t_unsigned_signed();
    t_narrow();
    t_always_and_other();
    t_call();
    t_exit();
    t_fault();
    t_illegal();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule